// File: doc/BRIEF.md
# Wait-Mode Clock Enable Controller

This block decides, cycle by cycle, which clock enables of a small microcontroller stay asserted while the core runs and while it sleeps in wait mode. A two-state machine (run, wait) accepts a wait request and returns to run on a wake event. Each clock domain has its own rule for wait. The processor clock always stops. The watchdog count clock stops unless the watchdog counts from the on-chip oscillator. The analog-converter clock and the three prescaled peripheral clocks stop only when the stop-in-wait control is set. The selectable f2n clock stops only when that control is set and f2n is fed from the main-path clock. The 32 kHz-derived clock never stops. The oscillators themselves keep running. Only the registered enables change.

Before it enters wait with the stop-in-wait control set, the block checks that the main clock divided by the programmed ratio is no faster than a threshold, 10 MHz by default. A request that fails this check is refused. The machine stays in run and raises a sticky illegal-entry flag, which clears at the next accepted request.

All outputs are registered in a single reference clock domain. The enables change on the same edge as the state.

Top module: `wait_clkgate_ctrl`

## Requirements
- R1: While reset is low at a clock edge, the state becomes run, every enable output becomes 1 and `bad_entry` becomes 0.
- R2: An accepted wait request (run state, `wait_req`=1, `wake_evt`=0, entry check met) moves the block to wait at that edge, and `en_cpu` becomes 0 on that edge. In run, `en_cpu` is 1.
- R3: In wait, `en_wdt` is 0 when `wdt_osc`=0 and 1 when `wdt_osc`=1. In run it is 1.
- R4: `en_per` has bit 0 for fAD, bit 1 for f1, bit 2 for f8 and bit 3 for f32. In wait all four bits are 0 when `per_stop`=1 and all are 1 when `per_stop`=0. In run they are 1.
- R5: `f2n_src` codes are 00 for the main-path clock, 01 for XIN, 10 for the on-chip oscillator, and 11, which is treated as 00. In wait, `en_f2n` is 0 only when `per_stop`=1 and `f2n_src` is 00 or 11. Otherwise it is 1.
- R6: `en_fc32` is 1 in every cycle.
- R7: When `cpu_src` is 00 (main) or 01 (PLL) and `per_stop`=1, a wait request is accepted only if `main_freq` (in MHz) is at most LIMIT_MHZ × 2^`div_sel`. A refused request leaves the block in run and sets `bad_entry` to 1 on that edge.
- R8: When `cpu_src` is 10 (sub clock) or 11 (on-chip oscillator), or when `per_stop`=0, the frequency check is bypassed and the request is accepted.
- R9: In wait, a `wake_evt` returns the block to run at the next edge, and all enables return to 1 on that edge.
- R10: A `wait_req` and a `wake_evt` in the same run cycle leave the block in run, and `bad_entry` keeps its value.
- R11: `bad_entry` stays set through later cycles and later refused requests. It becomes 0 on the edge of the next accepted request.
- R12: A `wait_req` that arrives while the block is in wait has no effect. The block stays in wait.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wait_req | input | 1 | Request to enter wait mode |
| wake_evt | input | 1 | Wake event, returns to run |
| per_stop | input | 1 | 1: peripheral clocks stop in wait |
| wdt_osc | input | 1 | 1: watchdog counts from on-chip oscillator |
| f2n_src | input | 2 | f2n clock source code (see R5) |
| cpu_src | input | 2 | CPU clock source code (see R7, R8) |
| main_freq | input | FREQ_W (8) | Main clock frequency in MHz |
| div_sel | input | DIV_W (3) | Divide ratio exponent, ratio = 2^div_sel |
| en_cpu | output | 1 | CPU clock enable |
| en_wdt | output | 1 | Watchdog count clock enable |
| en_per | output | 4 | fAD, f1, f8, f32 enables (bits 0..3) |
| en_f2n | output | 1 | f2n clock enable |
| en_fc32 | output | 1 | fC32 clock enable |
| bad_entry | output | 1 | Sticky illegal wait-entry flag |

## Verification
On every cycle, the assertions check the keep-alive rules: a watchdog on the oscillator, a clear stop control and an f2n source off the main path each force their enable on. They also check that the CPU enable follows the machine state, that a wake wins over a simultaneous request, that a wake in wait exits, and that a refused entry holds run and raises the flag. The bench's scenarios show the rest. These are the threshold boundary at exactly LIMIT × ratio and one step above it, the flag staying set across repeated refusals and clearing only on a later acceptance, the bypass for slow CPU sources, and control bits changing while the block sleeps. A reference model runs alongside over long random sequences.

// File: rtl/wcg_pkg.sv
// Package: shared encodings for the wait-mode clock enable controller.
// Assumes all users compile this file first.
package wcg_pkg;
    // Power-mode state of the controller
    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_WAIT = 1'b1
    } pm_state_t;

    // Source of the f2n peripheral clock
    typedef enum logic [1:0] {
        F2N_SEL = 2'b00,
        F2N_XIN = 2'b01,
        F2N_OSC = 2'b10,
        F2N_RSV = 2'b11
    } f2n_src_t;

    // Source feeding the CPU clock
    typedef enum logic [1:0] {
        CPU_MAIN = 2'b00,
        CPU_PLL  = 2'b01,
        CPU_SUB  = 2'b10,
        CPU_OSC  = 2'b11
    } cpu_src_t;

    // Number of peripheral clocks gated by the stop-in-wait control
    localparam int NUM_PER = 4;
endpackage

// File: rtl/wcg_div_check.sv
// Module: wcg_div_check
// Decides whether the divided CPU clock meets the wait-entry frequency limit.
// Assumes main_freq is in whole MHz and the divide ratio is 2**div_sel.
// Slow sources (sub clock, on-chip oscillator) always pass.
module wcg_div_check #(
    parameter int FREQ_W    = 8,
    parameter int DIV_W     = 3,
    parameter int LIMIT_MHZ = 10
) (
    input  logic [1:0]        cpu_src,
    input  logic [FREQ_W-1:0] main_freq,
    input  logic [DIV_W-1:0]  div_sel,
    output logic              div_ok
);
    import wcg_pkg::*;

    localparam int CMP_W = FREQ_W + (1 << DIV_W) + 8;

    logic [CMP_W-1:0] thr;
    logic [CMP_W-1:0] freq_ext;
    logic             fast_src;

    // Purpose: scale the limit by the divide ratio instead of dividing the frequency
    always_comb begin
        thr      = CMP_W'(LIMIT_MHZ) << div_sel;
        freq_ext = CMP_W'(main_freq);
    end

    // Purpose: identify the sources that come from the main oscillator path
    always_comb begin
        fast_src = (cpu_src_t'(cpu_src) == CPU_MAIN) || (cpu_src_t'(cpu_src) == CPU_PLL);
    end

    // Purpose: pass when the source is slow or the divided frequency is at most the limit
    always_comb begin
        div_ok = !fast_src || (freq_ext <= thr);
    end
endmodule

// File: rtl/wcg_mode_fsm.sv
// Module: wcg_mode_fsm
// Two-state run/wait machine with a sticky illegal-entry flag.
// Assumes div_ok is valid in the cycle of the request. A wake beats a request.
module wcg_mode_fsm (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wait_req,
    input  logic                wake_evt,
    input  logic                per_stop,
    input  logic                div_ok,
    output wcg_pkg::pm_state_t  state_q,
    output wcg_pkg::pm_state_t  state_nxt,
    output logic                bad_entry
);
    import wcg_pkg::*;

    logic accept;
    logic reject;

    // Purpose: next-state and request classification
    always_comb begin
        state_nxt = state_q;
        accept    = 1'b0;
        reject    = 1'b0;
        case (state_q)
            ST_RUN: begin
                if (wait_req && !wake_evt) begin
                    if (!per_stop || div_ok) begin
                        accept    = 1'b1;
                        state_nxt = ST_WAIT;
                    end else begin
                        reject = 1'b1;
                    end
                end
            end
            ST_WAIT: begin
                if (wake_evt) begin
                    state_nxt = ST_RUN;
                end
            end
            default: state_nxt = ST_RUN;
        endcase
    end

    // Purpose: state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_nxt;
        end
    end

    // Purpose: sticky flag, set on refusal and cleared on acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bad_entry <= 1'b0;
        end else if (accept) begin
            bad_entry <= 1'b0;
        end else if (reject) begin
            bad_entry <= 1'b1;
        end
    end

    // Simultaneous wake and request keeps run (R10)
    p_wake_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && wait_req && wake_evt) |=> (state_q == ST_RUN));

    // Flag is unchanged when wake and request coincide (R10)
    p_wake_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && wait_req && wake_evt) |=> $stable(bad_entry));

    // Wake in wait returns to run (R9)
    p_wake_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && wake_evt) |=> (state_q == ST_RUN));

    // Refused entry holds run and raises the flag (R7)
    p_refuse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && wait_req && !wake_evt && per_stop && !div_ok)
        |=> (state_q == ST_RUN && bad_entry));

    // Request in wait is ignored (R12)
    p_ignore_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && !wake_evt) |=> (state_q == ST_WAIT));

    // Accepted entry clears the flag (R11)
    p_flag_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && wait_req && !wake_evt && (!per_stop || div_ok))
        |=> (!bad_entry && state_q == ST_WAIT));
endmodule

// File: rtl/wcg_enable_gate.sv
// Module: wcg_enable_gate
// Registers every clock enable from the next state and the gating controls.
// Assumes the enables update on the same edge as the state register.
module wcg_enable_gate #(
    parameter int NPER = wcg_pkg::NUM_PER
) (
    input  logic                clk,
    input  logic                rst_n,
    input  wcg_pkg::pm_state_t  state_nxt,
    input  logic                per_stop,
    input  logic                wdt_osc,
    input  logic [1:0]          f2n_src,
    output logic                en_cpu,
    output logic                en_wdt,
    output logic [NPER-1:0]     en_per,
    output logic                en_f2n,
    output logic                en_fc32
);
    import wcg_pkg::*;

    logic going_wait;
    logic per_gate;
    logic f2n_on_main;

    // Purpose: decode the gating conditions for the coming cycle
    always_comb begin
        going_wait  = (state_nxt == ST_WAIT);
        per_gate    = going_wait && per_stop;
        f2n_on_main = (f2n_src_t'(f2n_src) == F2N_SEL) || (f2n_src_t'(f2n_src) == F2N_RSV);
    end

    // Purpose: CPU clock enable, off in wait
    always_ff @(posedge clk) begin
        if (!rst_n) en_cpu <= 1'b1;
        else        en_cpu <= !going_wait;
    end

    // Purpose: watchdog enable, kept on in wait when it counts from the oscillator
    always_ff @(posedge clk) begin
        if (!rst_n) en_wdt <= 1'b1;
        else        en_wdt <= !going_wait || wdt_osc;
    end

    // Purpose: one enable register per peripheral clock
    for (genvar gi = 0; gi < NPER; gi++) begin : g_per
        always_ff @(posedge clk) begin
            if (!rst_n) en_per[gi] <= 1'b1;
            else        en_per[gi] <= !per_gate;
        end
    end

    // Purpose: f2n enable, gated only when it runs from the main path
    always_ff @(posedge clk) begin
        if (!rst_n) en_f2n <= 1'b1;
        else        en_f2n <= !(per_gate && f2n_on_main);
    end

    // Purpose: fC32 enable, never gated by wait
    always_ff @(posedge clk) begin
        if (!rst_n) en_fc32 <= 1'b1;
        else        en_fc32 <= 1'b1;
    end

    // Oscillator-sourced watchdog keeps counting (R3)
    p_wdt_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_osc |=> en_wdt);

    // Clear stop control keeps peripheral clocks on (R4)
    p_per_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !per_stop |=> (&en_per));

    // f2n off the main path keeps running (R5)
    p_f2n_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !f2n_on_main |=> en_f2n);

    // All peripheral bits move together (R4)
    p_per_uniform_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> ((&en_per) || (en_per == '0)));
endmodule

// File: rtl/wait_clkgate_ctrl.sv
// Module: wait_clkgate_ctrl (top)
// Wait-mode clock enable controller: entry check, run/wait machine, enable registers.
// Assumes a single reference clock domain and a synchronous active-low reset.
module wait_clkgate_ctrl #(
    parameter int FREQ_W    = 8,
    parameter int DIV_W     = 3,
    parameter int LIMIT_MHZ = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wait_req,
    input  logic              wake_evt,
    input  logic              per_stop,
    input  logic              wdt_osc,
    input  logic [1:0]        f2n_src,
    input  logic [1:0]        cpu_src,
    input  logic [FREQ_W-1:0] main_freq,
    input  logic [DIV_W-1:0]  div_sel,
    output logic              en_cpu,
    output logic              en_wdt,
    output logic [3:0]        en_per,
    output logic              en_f2n,
    output logic              en_fc32,
    output logic              bad_entry
);
    import wcg_pkg::*;

    logic      div_ok;
    pm_state_t state_q;
    pm_state_t state_nxt;

    wcg_div_check #(
        .FREQ_W    (FREQ_W),
        .DIV_W     (DIV_W),
        .LIMIT_MHZ (LIMIT_MHZ)
    ) u_div (
        .cpu_src   (cpu_src),
        .main_freq (main_freq),
        .div_sel   (div_sel),
        .div_ok    (div_ok)
    );

    wcg_mode_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wait_req  (wait_req),
        .wake_evt  (wake_evt),
        .per_stop  (per_stop),
        .div_ok    (div_ok),
        .state_q   (state_q),
        .state_nxt (state_nxt),
        .bad_entry (bad_entry)
    );

    wcg_enable_gate #(
        .NPER (NUM_PER)
    ) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .state_nxt (state_nxt),
        .per_stop  (per_stop),
        .wdt_osc   (wdt_osc),
        .f2n_src   (f2n_src),
        .en_cpu    (en_cpu),
        .en_wdt    (en_wdt),
        .en_per    (en_per),
        .en_f2n    (en_f2n),
        .en_fc32   (en_fc32)
    );

    // CPU enable tracks the registered state (R2)
    p_cpu_state_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> (en_cpu == (state_q == ST_RUN)));

    // Leaving wait restores every enable (R9)
    p_exit_all_on_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && wake_evt) |=> (en_cpu && en_wdt && (&en_per) && en_f2n));
endmodule

// File: tb/wait_clkgate_ctrl_tb.sv
// Bench: behavioural reference model compared on every clock.
module wait_clkgate_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       wait_req, wake_evt, per_stop, wdt_osc;
    logic [1:0] f2n_src, cpu_src;
    logic [7:0] main_freq;
    logic [2:0] div_sel;
    logic       en_cpu, en_wdt, en_f2n, en_fc32, bad_entry;
    logic [3:0] en_per;

    int checks = 0;
    int errs   = 0;
    bit done   = 0;

    // reference model state
    bit m_wait = 0;
    bit m_ill  = 0;
    bit e_cpu = 1, e_wdt = 1, e_per = 1, e_f2n = 1;

    always #4 clk = ~clk;

    wait_clkgate_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .wait_req(wait_req), .wake_evt(wake_evt),
        .per_stop(per_stop), .wdt_osc(wdt_osc), .f2n_src(f2n_src), .cpu_src(cpu_src),
        .main_freq(main_freq), .div_sel(div_sel), .en_cpu(en_cpu), .en_wdt(en_wdt),
        .en_per(en_per), .en_f2n(en_f2n), .en_fc32(en_fc32), .bad_entry(bad_entry)
    );

    task automatic chk(input logic [3:0] act, input logic [3:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", errs, checks);
    endtask

    // model update for one edge, from the inputs present at that edge
    task automatic model_edge();
        bit ok;
        if (!rst_n) begin
            m_wait = 0; m_ill = 0;
        end else if (!m_wait) begin
            if (wait_req && !wake_evt) begin
                ok = !per_stop || cpu_src >= 2 ||
                     (int'(main_freq) <= 10 * (1 << int'(div_sel)));
                if (ok) begin m_wait = 1; m_ill = 0; end
                else    m_ill = 1;
            end
        end else if (wake_evt) begin
            m_wait = 0;
        end
        e_cpu = !m_wait;
        e_wdt = !m_wait || wdt_osc;
        e_per = !m_wait || !per_stop;
        e_f2n = e_per || f2n_src == 2'b01 || f2n_src == 2'b10;
    endtask

    // one clock: edge, model, then compare at the falling edge
    task automatic cyc();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk({3'b0, en_cpu},    {3'b0, e_cpu},     "R2 en_cpu");
        chk({3'b0, en_wdt},    {3'b0, e_wdt},     "R3 en_wdt");
        chk(en_per,            {4{e_per}},        "R4 en_per");
        chk({3'b0, en_f2n},    {3'b0, e_f2n},     "R5 en_f2n");
        chk({3'b0, en_fc32},   4'h1,              "R6 en_fc32");
        chk({3'b0, bad_entry}, {3'b0, m_ill},     "R11 bad_entry");
    endtask

    task automatic idle();
        wait_req = 0; wake_evt = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 0; wait_req = 1; wake_evt = 0; per_stop = 1; wdt_osc = 0;
        f2n_src = 2'b00; cpu_src = 2'b00; main_freq = 8'd200; div_sel = 3'd0;
        repeat (3) cyc();
        chk({en_cpu, en_wdt, en_f2n, en_fc32}, 4'hF, "R1 enables after reset");
        chk(en_per, 4'hF, "R1 peripheral enables after reset");
        chk({3'b0, bad_entry}, 4'h0, "R1 flag after reset");
        @(negedge clk); rst_n = 1; idle();
        cyc();

        // stop bit clear: peripherals stay on, watchdog stops
        per_stop = 0; main_freq = 8'd200; wait_req = 1; cyc(); idle();
        chk({3'b0, en_cpu}, 4'h0, "R2 cpu off in wait");
        chk(en_per, 4'hF, "R4 peripherals on with stop clear");
        chk({3'b0, bad_entry}, 4'h0, "R8 stop clear bypasses check");
        wait_req = 1; cyc(); idle(); cyc();
        chk({3'b0, en_cpu}, 4'h0, "R12 request in wait ignored");
        wake_evt = 1; cyc(); idle();
        chk({en_cpu, en_wdt, en_f2n, en_fc32}, 4'hF, "R9 wake restores enables");

        // legal entry at exact boundary: 20 MHz / 2 = 10 MHz
        per_stop = 1; main_freq = 8'd20; div_sel = 3'd1; wait_req = 1; cyc(); idle();
        chk({3'b0, en_cpu}, 4'h0, "R7 boundary accepted");
        chk(en_per, 4'h0, "R4 peripherals off with stop set");
        chk({3'b0, en_f2n}, 4'h0, "R5 f2n off on main path");
        f2n_src = 2'b01; cyc();
        chk({3'b0, en_f2n}, 4'h1, "R5 f2n on from XIN");
        f2n_src = 2'b10; cyc();
        chk({3'b0, en_f2n}, 4'h1, "R5 f2n on from oscillator");
        f2n_src = 2'b11; cyc();
        chk({3'b0, en_f2n}, 4'h0, "R5 reserved code gated");
        wdt_osc = 1; cyc();
        chk({3'b0, en_wdt}, 4'h1, "R3 watchdog on oscillator");
        wdt_osc = 0; cyc();
        chk({3'b0, en_wdt}, 4'h0, "R3 watchdog stopped");
        wake_evt = 1; cyc(); idle(); f2n_src = 2'b00;

        // one step above the limit: 21 MHz / 2
        main_freq = 8'd21; wait_req = 1; cyc(); idle();
        chk({en_cpu, bad_entry, 2'b00}, 4'hC, "R7 refused, run and flag");
        cyc();
        chk({3'b0, bad_entry}, 4'h1, "R11 flag sticky");
        cpu_src = 2'b01; main_freq = 8'd81; div_sel = 3'd3; wait_req = 1; cyc(); idle();
        chk({en_cpu, bad_entry, 2'b00}, 4'hC, "R7 PLL refused above 80");
        wait_req = 1; wake_evt = 1; main_freq = 8'd80; cyc(); idle();
        chk({en_cpu, bad_entry, 2'b00}, 4'hC, "R10 wake wins, flag kept");
        cpu_src = 2'b10; main_freq = 8'd255; div_sel = 3'd0; wait_req = 1; cyc(); idle();
        chk({en_cpu, bad_entry, 2'b00}, 4'h0, "R8 sub source bypass, R11 flag cleared");
        wake_evt = 1; cyc(); idle();
        cpu_src = 2'b11; wait_req = 1; cyc(); idle();
        chk({3'b0, en_cpu}, 4'h0, "R8 oscillator source bypass");
        wake_evt = 1; cyc(); idle();

        // random sequences against the model
        for (int i = 0; i < 3000; i++) begin
            wait_req  = ($urandom % 3) == 0;
            wake_evt  = ($urandom % 5) == 0;
            per_stop  = $urandom % 2;
            wdt_osc   = $urandom % 2;
            f2n_src   = 2'($urandom);
            cpu_src   = 2'($urandom);
            main_freq = 8'($urandom);
            div_sel   = 3'($urandom);
            if (($urandom % 200) == 0) rst_n = 0; else rst_n = 1;
            cyc();
        end

        done = 1;
        summary();
        $finish;
    end
endmodule